// File: doc/BRIEF.md
# Two-Wire Target with Guarded Register Spaces

This block is the serial front end of a supply-control device. It watches a two-wire bus (clock and open-drain data), recognises START and STOP, and answers address bytes aimed at one of three spaces: a byte memory split into two 256-byte halves, a 16-entry configuration bank, and a command space. The command space holds the write-guard register and two extra configuration registers. A write carries the address byte, then a pointer byte, then any number of data bytes. A read first sets the pointer with a write that has no STOP, then sends a repeated START with the read bit. After that, bytes stream out from the pointer for as long as the controller acknowledges.

Writes pass through two gates. The first is a volatile guard register that starts out protective and has separate unlock nibbles for memory and for configuration. The second is a sticky lock bit that freezes configuration once it is set. A blocked byte is still acknowledged, so the bus sequence looks the same whether or not the write lands.

The only data path is the bus. There is no clock stretching and no back-pressure, so each byte must be taken or supplied inside its own bit times. A `bus_busy_o` level lets neighbouring logic pause while a transfer to this target is open. A one-cycle `commit_o` pulse after STOP tells the storage sequencer that persistent contents changed.

Top module: `i2ct_top`

## Requirements
- R1: An address byte is {type[3:0], A[2:0], R/W}. Type 1010 answers, or 1011 instead when setup bit 0 is 1. With that type, A[1:0]=00 selects memory half 0, 01 selects half 1, 11 selects configuration and 10 gets no ACK. Type 1001 selects the command space only when A[1:0] equals setup bits [3:2]. Any other address gets no ACK, and the target never drives SDA until the next START.
- R2: When setup bit 1 is 0, A[2] must be 0. When setup bit 1 is 1, A[2] must equal `a2_pin_i`.
- R3: In a write, the address, pointer and every data byte are ACKed. Each stored byte advances only the low four pointer bits, so the writes wrap inside the 16-byte page.
- R4: After a repeated START with the read bit, the target returns the byte at the pointer. Each controller ACK advances the full 8-bit pointer, wrapping 0xFF to 0x00. A controller NACK ends the read.
- R5: Bits go MSB first and are sampled on the SCL rising edge. The target changes its SDA drive only while SCL is low, and it signals a 0 or an ACK by pulling SDA low.
- R6: The guard register is at command address 0x87 and resets to 0x00. Memory writes land only when its upper nibble is 0101. Configuration writes (the configuration space plus command 0x83/0x84) land only when its lower nibble is 0101. Blocked bytes are ACKed and discarded. Address 0x87 is always writable.
- R7: Setup bit 7 is the lock. Once it is 1, every configuration write is discarded until reset, whatever the guard register holds.
- R8: Command addresses 0x83 and 0x84 hold read/write registers and 0x87 reads back the guard. Every other command address reads 0x00 and discards writes.
- R9: `bus_busy_o` rises with the ACK of a matching address and falls at STOP. An address that gets no ACK leaves it low.
- R10: `commit_o` pulses for exactly one cycle at STOP, and only when the transfer stored at least one byte in memory, configuration, 0x83 or 0x84.
- R11: After reset, SDA is released, `bus_busy_o` and `commit_o` are low, and all storage, the guard and setup (configuration entry 0) read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level |
| a2_pin_i | input | 1 | Strap level for address bit A[2] |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| bus_busy_o | output | 1 | High from own address ACK to STOP |
| commit_o | output | 1 | One-cycle pulse after a transfer that stored data |

## Verification
The bench builds the block with its default parameters: an 8-bit pointer, a 16-byte page, 16 configuration entries and a two-stage input synchroniser, with each quarter bit lasting ten system clocks. These values bring two boundaries within reach in a short run: a page write that crosses the page end, and a read that crosses the end of a 256-byte half. A behavioural model of the spaces, the guard and the setup bits predicts every ACK, read byte, busy level and commit count as the setup register changes the addressing partway through the run.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
  typedef enum logic [1:0] {SP_MEM = 2'd0, SP_CFG = 2'd1, SP_CMD = 2'd2} space_e;
  typedef enum logic [2:0] {ST_IDLE, ST_ADDR, ST_PTR, ST_WDAT, ST_ACK, ST_RDAT, ST_RACK} st_e;
  typedef struct packed {
    logic       lock;
    logic [1:0] cmd_bus;
    logic       a2_pin_sel;
    logic       alt_type;
  } setup_t;
endpackage

// File: rtl/i2ct_sync.sv
module i2ct_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [STAGES-1:0] scl_sr, sda_sr;
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sr <= '1;
      sda_sr <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sr <= {scl_sr[STAGES-2:0], scl_i};
      sda_sr <= {sda_sr[STAGES-2:0], sda_i};
      scl_p  <= scl_lvl;
      sda_p  <= sda_lvl;
    end
  end

  assign scl_lvl  = scl_sr[STAGES-1];
  assign sda_lvl  = sda_sr[STAGES-1];
  assign scl_rise = scl_lvl & ~scl_p;
  assign scl_fall = ~scl_lvl & scl_p;
  // data edges while the clock stays high frame a transfer
  assign start_ev = scl_lvl & scl_p & sda_p & ~sda_lvl;
  assign stop_ev  = scl_lvl & scl_p & ~sda_p & sda_lvl;
endmodule

// File: rtl/i2ct_link.sv
module i2ct_link
  import i2ct_pkg::*;
#(
  parameter int         PTR_W    = 8,
  parameter int         PAGE_W   = 4,
  parameter logic [3:0] TYPE_MEM = 4'b1010,
  parameter logic [3:0] TYPE_ALT = 4'b1011,
  parameter logic [3:0] TYPE_CMD = 4'b1001
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sda_lvl,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_ev,
  input  logic             stop_ev,
  input  logic             a2_pin,
  input  setup_t           setup,
  input  logic [7:0]       rd_byte,
  input  logic             wr_keep,
  output logic             sda_oe,
  output logic             bus_busy,
  output logic             commit,
  output space_e           space,
  output logic             half,
  output logic [PTR_W-1:0] ptr,
  output logic             wr_stb,
  output logic [7:0]       wr_data
);
  localparam logic [PTR_W-1:0]  PTR_ONE = 1;
  localparam logic [PAGE_W-1:0] PG_ONE  = 1;

  st_e        st, nxt;
  logic [2:0] bcnt;
  logic       done, more, dirty;
  logic [7:0] sh, tx;

  logic       a2_exp, hit_mem, hit_cmd;
  logic [3:0] mem_id;

  always_comb begin
    a2_exp  = setup.a2_pin_sel ? a2_pin : 1'b0;
    mem_id  = setup.alt_type ? TYPE_ALT : TYPE_MEM;
    hit_mem = (sh[7:4] == mem_id) && (sh[3] == a2_exp) && (sh[2:1] != 2'b10);
    hit_cmd = (sh[7:4] == TYPE_CMD) && (sh[3] == a2_exp) && (sh[2:1] == setup.cmd_bus);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; nxt <= ST_IDLE;
      bcnt <= '0; done <= 1'b0; more <= 1'b0; dirty <= 1'b0;
      sh <= '0; tx <= '0;
      sda_oe <= 1'b0; bus_busy <= 1'b0; commit <= 1'b0;
      space <= SP_MEM; half <= 1'b0; ptr <= '0;
      wr_stb <= 1'b0; wr_data <= '0;
    end else begin
      wr_stb <= 1'b0;
      commit <= 1'b0;
      if (wr_stb) begin
        ptr <= {ptr[PTR_W-1:PAGE_W], ptr[PAGE_W-1:0] + PG_ONE};
        if (wr_keep) dirty <= 1'b1;
      end
      if (stop_ev) begin
        st <= ST_IDLE; sda_oe <= 1'b0; bus_busy <= 1'b0;
        commit <= dirty; dirty <= 1'b0;
      end else if (start_ev) begin
        st <= ST_ADDR; bcnt <= '0; done <= 1'b0; sda_oe <= 1'b0;
      end else begin
        case (st)
          ST_ADDR, ST_PTR, ST_WDAT: begin
            if (scl_rise) begin
              sh   <= {sh[6:0], sda_lvl};
              bcnt <= bcnt + 3'd1;
              if (bcnt == 3'd7) done <= 1'b1;
            end else if (scl_fall && done) begin
              done <= 1'b0;
              bcnt <= '0;
              if (st == ST_ADDR) begin
                if (hit_mem || hit_cmd) begin
                  space    <= hit_cmd ? SP_CMD : ((sh[2:1] == 2'b11) ? SP_CFG : SP_MEM);
                  half     <= sh[1];
                  sda_oe   <= 1'b1;
                  bus_busy <= 1'b1;
                  nxt      <= sh[0] ? ST_RDAT : ST_PTR;
                  st       <= ST_ACK;
                end else begin
                  st <= ST_IDLE;
                end
              end else if (st == ST_PTR) begin
                ptr <= sh; sda_oe <= 1'b1; nxt <= ST_WDAT; st <= ST_ACK;
              end else begin
                wr_stb <= 1'b1; wr_data <= sh; sda_oe <= 1'b1; nxt <= ST_WDAT; st <= ST_ACK;
              end
            end
          end
          ST_ACK: if (scl_fall) begin
            st   <= nxt;
            bcnt <= '0;
            if (nxt == ST_RDAT) begin
              tx <= rd_byte; sda_oe <= ~rd_byte[7];
            end else begin
              sda_oe <= 1'b0;
            end
          end
          ST_RDAT: begin
            if (scl_rise) begin
              bcnt <= bcnt + 3'd1;
              if (bcnt == 3'd7) done <= 1'b1;
            end else if (scl_fall) begin
              if (done) begin
                done <= 1'b0; sda_oe <= 1'b0; st <= ST_RACK; ptr <= ptr + PTR_ONE;
              end else begin
                tx <= {tx[6:0], 1'b0}; sda_oe <= ~tx[6];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) more <= ~sda_lvl;
            else if (scl_fall) begin
              if (more) begin
                st <= ST_RDAT; bcnt <= '0; tx <= rd_byte; sda_oe <= ~rd_byte[7];
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2ct_store.sv
module i2ct_store
  import i2ct_pkg::*;
#(
  parameter int         PTR_W   = 8,
  parameter int         CFG_W   = 4,
  parameter logic [7:0] GUARD_A = 8'h87,
  parameter logic [7:0] XA_A    = 8'h83,
  parameter logic [7:0] XB_A    = 8'h84,
  parameter logic [3:0] OPEN    = 4'b0101
) (
  input  logic             clk,
  input  logic             rst_n,
  input  space_e           space,
  input  logic             half,
  input  logic [PTR_W-1:0] ptr,
  input  logic             wr_stb,
  input  logic [7:0]       wr_data,
  output logic [7:0]       rd_byte,
  output logic             wr_keep,
  output setup_t           setup,
  output logic [7:0]       guard_o
);
  localparam int MEM_N = 2 ** (PTR_W + 1);
  localparam int CFG_N = 2 ** CFG_W;

  logic [7:0] mem [MEM_N];
  logic [7:0] cfg [CFG_N];
  logic [7:0] xa, xb, guard;
  logic       mem_open, cfg_open, is_xa, is_xb, is_guard;

  assign setup   = '{lock: cfg[0][7], cmd_bus: cfg[0][3:2], a2_pin_sel: cfg[0][1], alt_type: cfg[0][0]};
  assign guard_o = guard;

  always_comb begin
    mem_open = (guard[7:4] == OPEN);
    cfg_open = (guard[3:0] == OPEN) && !setup.lock;
    is_xa    = ({{(8 > PTR_W ? 8 - PTR_W : 0){1'b0}}, ptr} == XA_A);
    is_xb    = ({{(8 > PTR_W ? 8 - PTR_W : 0){1'b0}}, ptr} == XB_A);
    is_guard = ({{(8 > PTR_W ? 8 - PTR_W : 0){1'b0}}, ptr} == GUARD_A);
    case (space)
      SP_MEM: begin wr_keep = mem_open; rd_byte = mem[{half, ptr}]; end
      SP_CFG: begin wr_keep = cfg_open; rd_byte = cfg[ptr[CFG_W-1:0]]; end
      SP_CMD: begin
        wr_keep = (is_xa || is_xb) && cfg_open;
        rd_byte = is_xa ? xa : (is_xb ? xb : (is_guard ? guard : 8'h00));
      end
      default: begin wr_keep = 1'b0; rd_byte = 8'h00; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_N; i++) mem[i] <= '0;
      for (int j = 0; j < CFG_N; j++) cfg[j] <= '0;
      xa <= '0; xb <= '0; guard <= '0;
    end else if (wr_stb) begin
      case (space)
        SP_MEM: if (wr_keep) mem[{half, ptr}] <= wr_data;
        SP_CFG: if (wr_keep) cfg[ptr[CFG_W-1:0]] <= wr_data;
        SP_CMD: begin
          if (is_guard) guard <= wr_data;
          if (wr_keep && is_xa) xa <= wr_data;
          if (wr_keep && is_xb) xb <= wr_data;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2ct_top.sv
module i2ct_top
  import i2ct_pkg::*;
#(
  parameter int         PTR_W       = 8,
  parameter int         PAGE_W      = 4,
  parameter int         CFG_W       = 4,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] TYPE_MEM    = 4'b1010,
  parameter logic [3:0] TYPE_ALT    = 4'b1011,
  parameter logic [3:0] TYPE_CMD    = 4'b1001
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic a2_pin_i,
  output logic sda_oe_o,
  output logic bus_busy_o,
  output logic commit_o
);
  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;
  space_e space;
  logic half, wr_stb_w, wr_keep, lock_w;
  logic [PTR_W-1:0] ptr;
  logic [7:0] wr_data, rd_byte, wp_w;
  setup_t setup;

  assign lock_w = setup.lock;

  i2ct_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  i2ct_link #(.PTR_W(PTR_W), .PAGE_W(PAGE_W), .TYPE_MEM(TYPE_MEM),
              .TYPE_ALT(TYPE_ALT), .TYPE_CMD(TYPE_CMD)) u_link (
    .clk(clk), .rst_n(rst_n), .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev), .a2_pin(a2_pin_i), .setup(setup),
    .rd_byte(rd_byte), .wr_keep(wr_keep), .sda_oe(sda_oe_o), .bus_busy(bus_busy_o),
    .commit(commit_o), .space(space), .half(half), .ptr(ptr), .wr_stb(wr_stb_w),
    .wr_data(wr_data)
  );

  i2ct_store #(.PTR_W(PTR_W), .CFG_W(CFG_W)) u_store (
    .clk(clk), .rst_n(rst_n), .space(space), .half(half), .ptr(ptr), .wr_stb(wr_stb_w),
    .wr_data(wr_data), .rd_byte(rd_byte), .wr_keep(wr_keep), .setup(setup), .guard_o(wp_w)
  );
endmodule

// File: rtl/i2ct_chk.sv
module i2ct_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_lvl,
  input logic       sda_oe_o,
  input logic       bus_busy_o,
  input logic       commit_o,
  input logic       lock_w,
  input logic [7:0] wp_w,
  input logic       wr_stb_w
);
  p_sda_scl_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_o) |-> !$past(scl_lvl));
  p_busy_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_busy_o) |-> sda_oe_o);
  p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_busy_o |-> !sda_oe_o);
  p_commit_one_r10: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |=> !commit_o);
  p_commit_free_r10: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |-> !bus_busy_o);
  p_lock_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lock_w |=> lock_w);
  p_guard_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wp_w) |-> $past(wr_stb_w));
endmodule

bind i2ct_top i2ct_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .sda_oe_o(sda_oe_o),
  .bus_busy_o(bus_busy_o), .commit_o(commit_o), .lock_w(lock_w), .wp_w(wp_w),
  .wr_stb_w(wr_stb_w)
);

// File: tb/sim_i2ct_top.sv
module sim_i2ct_top;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_d = 1'b1, sda_d = 1'b1, a2_pin = 1'b0;
  logic sda_oe_o, bus_busy_o, commit_o;
  logic sda_w;
  int n_chk = 0, n_fail = 0, n_commit = 0;

  logic [7:0] mmem [512];
  logic [7:0] mcfg [16];
  logic [7:0] m83 = 8'h00, m84 = 8'h00, mwp = 8'h00;
  logic [7:0] wq[$];

  always #2 clk = ~clk;
  assign sda_w = sda_d & ~sda_oe_o;

  i2ct_top u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_d), .sda_i(sda_w), .a2_pin_i(a2_pin),
    .sda_oe_o(sda_oe_o), .bus_busy_o(bus_busy_o), .commit_o(commit_o)
  );

  always @(negedge clk) if (rst_n && commit_o) n_commit++;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq_t; repeat (Q) @(negedge clk); endtask
  task automatic bstart; sda_d = 1; wq_t(); scl_d = 1; wq_t(); sda_d = 0; wq_t(); scl_d = 0; wq_t(); endtask
  task automatic bstop; sda_d = 0; wq_t(); scl_d = 1; wq_t(); sda_d = 1; wq_t(); endtask
  task automatic wbit(input logic b); sda_d = b; wq_t(); scl_d = 1; wq_t(); wq_t(); scl_d = 0; wq_t(); endtask
  task automatic rbit(output logic b); sda_d = 1; wq_t(); scl_d = 1; wq_t(); b = sda_w; wq_t(); scl_d = 0; wq_t(); endtask
  task automatic wbyte(input logic [7:0] v, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) wbit(v[i]);
    rbit(a); ack = !a;
  endtask
  task automatic rbyte(input logic ackit, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) rbit(v[i]);
    wbit(!ackit);
  endtask

  // model: -1 no answer, 0 memory, 1 configuration, 2 command
  function automatic int m_decode(input logic [3:0] tp, input logic [2:0] a3);
    logic a2e; logic [3:0] mid;
    a2e = mcfg[0][1] ? a2_pin : 1'b0;
    mid = mcfg[0][0] ? 4'hB : 4'hA;
    if (a3[2] != a2e) return -1;
    if (tp == mid && a3[1:0] != 2'b10) return (a3[1:0] == 2'b11) ? 1 : 0;
    if (tp == 4'h9 && a3[1:0] == mcfg[0][3:2]) return 2;
    return -1;
  endfunction

  function automatic logic [7:0] m_rd(input int sp, input logic hf, input logic [7:0] p);
    if (sp == 0) return mmem[{hf, p}];
    if (sp == 1) return mcfg[p[3:0]];
    if (p == 8'h83) return m83;
    if (p == 8'h84) return m84;
    if (p == 8'h87) return mwp;
    return 8'h00;
  endfunction

  function automatic logic m_wr(input int sp, input logic hf, input logic [7:0] p, input logic [7:0] d);
    logic cfg_ok;
    cfg_ok = (mwp[3:0] == 4'b0101) && !mcfg[0][7];
    if (sp == 0) begin if (mwp[7:4] == 4'b0101) begin mmem[{hf, p}] = d; return 1; end return 0; end
    if (sp == 1) begin if (cfg_ok) begin mcfg[p[3:0]] = d; return 1; end return 0; end
    if (p == 8'h87) begin mwp = d; return 0; end
    if (p == 8'h83 && cfg_ok) begin m83 = d; return 1; end
    if (p == 8'h84 && cfg_ok) begin m84 = d; return 1; end
    return 0;
  endfunction

  task automatic do_write(input string tag, input logic [3:0] tp, input logic [2:0] a3, input logic [7:0] p0);
    int sp, c0; logic ack, nv; logic [7:0] p;
    sp = m_decode(tp, a3); c0 = n_commit; nv = 0; p = p0;
    bstart();
    wbyte({tp, a3, 1'b0}, ack);
    chk({tag, " R1 R2 addr ack"}, ack, sp >= 0);
    chk({tag, " R9 busy after addr"}, bus_busy_o, sp >= 0);
    if (sp >= 0) begin
      wbyte(p0, ack); chk({tag, " R3 ptr ack"}, ack, 1);
      foreach (wq[k]) begin
        wbyte(wq[k], ack); chk({tag, " R3 R6 data ack"}, ack, 1);
        if (m_wr(sp, a3[0], p, wq[k])) nv = 1;
        p = {p[7:4], p[3:0] + 4'd1};
      end
    end
    bstop(); repeat (4) @(negedge clk);
    chk({tag, " R9 busy after stop"}, bus_busy_o, 0);
    chk({tag, " R10 commit count"}, n_commit - c0, nv ? 1 : 0);
    wq.delete();
  endtask

  task automatic do_read(input string tag, input logic [3:0] tp, input logic [2:0] a3, input logic [7:0] p0, input int n);
    int sp, c0; logic ack; logic [7:0] p, v;
    sp = m_decode(tp, a3); c0 = n_commit; p = p0;
    bstart();
    wbyte({tp, a3, 1'b0}, ack);
    chk({tag, " R1 R2 addr ack"}, ack, sp >= 0);
    if (sp >= 0) begin
      wbyte(p0, ack);
      bstart();
      wbyte({tp, a3, 1'b1}, ack); chk({tag, " R4 read addr ack"}, ack, 1);
      for (int k = 0; k < n; k++) begin
        rbyte(k != n - 1, v);
        chk({tag, " R4 R5 read data"}, v, m_rd(sp, a3[0], p));
        p = p + 8'd1;
      end
    end
    bstop(); repeat (4) @(negedge clk);
    chk({tag, " R10 no commit on read"}, n_commit - c0, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 512; i++) mmem[i] = 8'h00;
    for (int i = 0; i < 16; i++) mcfg[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R11 sda released", sda_oe_o, 0);
    chk("R11 busy low", bus_busy_o, 0);
    chk("R11 commit low", commit_o, 0);
    do_read("R11 mem reset", 4'hA, 3'b000, 8'h10, 2);
    do_read("R11 guard reset", 4'h9, 3'b000, 8'h87, 1);

    wq = '{8'h12, 8'h34};
    do_write("R6 guarded mem", 4'hA, 3'b000, 8'h10);
    do_read("R6 guarded readback", 4'hA, 3'b000, 8'h10, 2);

    do_write("R1 bad type", 4'h5, 3'b000, 8'h00);
    do_write("R1 A10 reserved", 4'hA, 3'b010, 8'h00);

    wq = '{8'h50};
    do_write("R6 open mem", 4'h9, 3'b000, 8'h87);
    do_read("R6 guard value", 4'h9, 3'b000, 8'h87, 1);

    wq = '{8'hA1, 8'hB2, 8'hC3};
    do_write("R3 burst", 4'hA, 3'b000, 8'h10);
    do_read("R4 burst readback", 4'hA, 3'b000, 8'h10, 3);

    for (int i = 0; i < 18; i++) wq.push_back(8'h40 + 8'(i));
    do_write("R3 page wrap", 4'hA, 3'b000, 8'h2E);
    do_read("R3 page readback", 4'hA, 3'b000, 8'h20, 16);

    wq = '{8'h5A, 8'h6B};
    do_write("R1 half one", 4'hA, 3'b001, 8'h10);
    do_read("R1 half one readback", 4'hA, 3'b001, 8'h10, 2);
    do_read("R1 half zero intact", 4'hA, 3'b000, 8'h10, 2);

    wq = '{8'h77};
    do_write("R1 mem FF", 4'hA, 3'b000, 8'hFF);
    do_read("R4 pointer wrap", 4'hA, 3'b000, 8'hFF, 2);

    wq = '{8'hA5};
    do_write("R6 guarded cfg", 4'hA, 3'b011, 8'h05);
    wq = '{8'h11};
    do_write("R6 guarded x83", 4'h9, 3'b000, 8'h83);
    do_read("R6 cfg readback", 4'hA, 3'b011, 8'h05, 1);

    wq = '{8'h55};
    do_write("R6 open both", 4'h9, 3'b000, 8'h87);
    wq = '{8'hA5};
    do_write("R6 cfg write", 4'hA, 3'b011, 8'h05);
    wq = '{8'h11, 8'h22};
    do_write("R8 extra regs", 4'h9, 3'b000, 8'h83);
    wq = '{8'h99};
    do_write("R8 unused cmd", 4'h9, 3'b000, 8'h90);
    do_read("R8 extra readback", 4'h9, 3'b000, 8'h83, 2);
    do_read("R8 unused reads zero", 4'h9, 3'b000, 8'h90, 1);
    do_read("R6 cfg value", 4'hA, 3'b011, 8'h05, 1);

    wq = '{8'h01};
    do_write("R1 alt type", 4'hA, 3'b011, 8'h00);
    do_read("R1 old type silent", 4'hA, 3'b000, 8'h10, 1);
    do_read("R1 alt type answers", 4'hB, 3'b000, 8'h10, 1);

    a2_pin = 1'b1;
    wq = '{8'h03};
    do_write("R2 pin select", 4'hB, 3'b011, 8'h00);
    do_read("R2 A2 zero silent", 4'hB, 3'b011, 8'h00, 1);
    do_read("R2 A2 one answers", 4'hB, 3'b111, 8'h00, 1);

    wq = '{8'h0B};
    do_write("R1 cmd bits", 4'hB, 3'b111, 8'h00);
    do_read("R1 cmd old bits silent", 4'h9, 3'b100, 8'h87, 1);
    do_read("R1 cmd new bits answer", 4'h9, 3'b110, 8'h87, 1);

    wq = '{8'h8B};
    do_write("R7 set lock", 4'hB, 3'b111, 8'h00);
    wq = '{8'h00};
    do_write("R7 locked cfg", 4'hB, 3'b111, 8'h05);
    wq = '{8'hEE};
    do_write("R7 locked x83", 4'h9, 3'b110, 8'h83);
    wq = '{8'h00};
    do_write("R7 guard still writable", 4'h9, 3'b110, 8'h87);
    wq = '{8'h55};
    do_write("R7 reopen guard", 4'h9, 3'b110, 8'h87);
    wq = '{8'h00};
    do_write("R7 locked after reopen", 4'hB, 3'b111, 8'h00);
    do_read("R7 cfg frozen", 4'hB, 3'b111, 8'h00, 6);
    do_read("R7 x83 frozen", 4'h9, 3'b110, 8'h83, 5);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule